// File: doc/BRIEF.md
# Keypad Colour-Code Door Lock

This block controls a door latch from a small keypad. The keypad has one arming button and three colour buttons: red, green and blue. The door opens only when the arming button is pressed first and the colour buttons then follow in the order red, blue, green, red.

All inputs come in already synchronized to the clock, and each press lasts exactly one cycle. A separate press-valid input marks the cycles in which a colour button is pressed. While no press is valid, the block waits as long as needed. A valid press of the wrong colour sends the lock back to idle. From there the arming button must be pressed again before a new attempt can start.

The block is a Moore machine with six states held in a 3-bit register. The unlock output is high for exactly one cycle, in the state reached by the final correct press.

Top module: `keypad_code_lock`

## Requirements
- R1: While `rst` is high at a rising edge, the machine goes to idle, and `unlock_o` is 0 in the following cycle.
- R2: In idle, only `start_i` has an effect. Colour presses (`press_i` with any colour flag) leave the machine idle, so they never lead to an unlock without a later arming press.
- R3: After an arming press, valid presses of red, then blue, then green, then red drive `unlock_o` to 1 in the cycle right after the edge that captures the final red press.
- R4: In each checking state, a cycle with `press_i`=0 keeps the current progress, so pauses of any length between presses do not affect the result.
- R5: In each checking state, a valid press whose expected colour flag is 0 returns the machine to idle. Colours pressed after that do not unlock until there is a new arming press. A valid press with no colour flag set counts as wrong.
- R6: `unlock_o` is high for exactly one cycle. The machine then returns to idle whatever the inputs are, including `start_i`.
- R7: When several colour flags are set in one valid press, the press counts as correct if the expected colour is among them.
- R8: Colour flags with `press_i`=0 are not presses and do not change progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Arming button pressed this cycle |
| press_i | input | 1 | A colour press is valid this cycle |
| red_i | input | 1 | Red button flag |
| green_i | input | 1 | Green button flag |
| blue_i | input | 1 | Blue button flag |
| unlock_o | output | 1 | Door unlock, a one-cycle pulse |

## Verification
Every result of this block is due one cycle after its stimulus. The state register captures the inputs at a rising edge, and `unlock_o` decodes that register with no further delay. The driver applies each cycle's inputs on the falling edge and queues the unlock value that a bench-side model of the requirements predicts for the next rising edge. The monitor takes one item from the queue a short delay after each rising edge and compares it with `unlock_o`, so every comparison is paired with the press that caused it.

// File: rtl/keypad_code_lock.sv
module keypad_code_lock #(
  parameter int STATE_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic press_i,
  input  logic red_i,
  input  logic green_i,
  input  logic blue_i,
  output logic unlock_o
);

  typedef enum logic [STATE_W-1:0] {
    LK_IDLE  = 3'd0,
    LK_ARMED = 3'd1,
    LK_GOT_R = 3'd2,
    LK_GOT_B = 3'd3,
    LK_GOT_G = 3'd4,
    LK_OPEN  = 3'd5
  } lk_state_e;

  lk_state_e state_q, state_d;
  logic      hit;

  always_comb begin
    case (state_q)
      LK_ARMED, LK_GOT_G: hit = red_i;
      LK_GOT_R:           hit = blue_i;
      LK_GOT_B:           hit = green_i;
      default:            hit = 1'b0;
    endcase
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      LK_IDLE:  state_d = start_i ? LK_ARMED : LK_IDLE;
      LK_ARMED: if (press_i) state_d = hit ? LK_GOT_R : LK_IDLE;
      LK_GOT_R: if (press_i) state_d = hit ? LK_GOT_B : LK_IDLE;
      LK_GOT_B: if (press_i) state_d = hit ? LK_GOT_G : LK_IDLE;
      LK_GOT_G: if (press_i) state_d = hit ? LK_OPEN  : LK_IDLE;
      default:  state_d = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= LK_IDLE;
    else     state_q <= state_d;
  end

  assign unlock_o = (state_q == LK_OPEN);

endmodule

module keypad_code_lock_chk (
  input logic       clk,
  input logic       rst,
  input logic       press_i,
  input logic       red_i,
  input logic [2:0] state_q,
  input logic       unlock_o
);

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!unlock_o && state_q == 3'd0)); // R1

  AST_IDLE_STAYS_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (state_q == 3'd0) |=> !unlock_o); // R2

  AST_OPEN_AFTER_RED: assert property (@(posedge clk) disable iff (rst)
    $rose(unlock_o) |-> ($past(press_i) && $past(red_i))); // R3

  AST_PAUSE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q >= 3'd1 && state_q <= 3'd4 && !press_i) |=> $stable(state_q)); // R4

  AST_WRONG_ABORTS: assert property (@(posedge clk) disable iff (rst)
    (state_q == 3'd1 && press_i && !red_i) |=> (state_q == 3'd0)); // R5

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    unlock_o |=> (!unlock_o && state_q == 3'd0)); // R6

endmodule

bind keypad_code_lock keypad_code_lock_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .press_i  (press_i),
  .red_i    (red_i),
  .state_q  (state_q),
  .unlock_o (unlock_o)
);

// File: tb/keypad_code_lock_bench.sv
module keypad_code_lock_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, press_i = 1'b0, red_i = 1'b0, green_i = 1'b0, blue_i = 1'b0;
  logic unlock_o;

  always #5 clk = ~clk;

  keypad_code_lock u_keypad_code_lock (
    .clk(clk), .rst(rst), .start_i(start_i), .press_i(press_i),
    .red_i(red_i), .green_i(green_i), .blue_i(blue_i), .unlock_o(unlock_o)
  );

  typedef struct {
    logic  exp;
    string tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  int    mstage = 0;
  bit    done   = 0;

  task automatic step(input bit rs, input bit st, input bit pr,
                      input bit r, input bit g, input bit b, input string tag);
    item_t it;
    bit    ok;
    @(negedge clk);
    rst = rs; start_i = st; press_i = pr; red_i = r; green_i = g; blue_i = b;
    case (mstage)
      1, 4:    ok = r;
      2:       ok = b;
      3:       ok = g;
      default: ok = 0;
    endcase
    if (rs)               mstage = 0;
    else if (mstage == 0) mstage = st ? 1 : 0;
    else if (mstage == 5) mstage = 0;
    else if (pr)          mstage = ok ? mstage + 1 : 0;
    it.exp = (mstage == 5);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic code(input string tag);
    step(0, 0, 1, 1, 0, 0, tag);
    step(0, 0, 1, 0, 0, 1, tag);
    step(0, 0, 1, 0, 1, 0, tag);
    step(0, 0, 1, 1, 0, 0, tag);
  endtask

  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (unlock_o !== it.exp) begin
        errors++;
        $display("FAIL %s: unlock_o=%b expected %b at %0t", it.tag, unlock_o, it.exp, $time);
      end
    end
  end

  initial begin
    for (int c = 0; c < 5000; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step(1, 0, 0, 0, 0, 0, "R1");
    // R2: colour presses in idle
    code("R2");
    idle(2, "R2");
    // R8: flags without press while armed
    step(0, 1, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 0, 0, "R8");
    step(0, 0, 0, 0, 1, 1, "R8");
    code("R8");
    step(0, 0, 0, 0, 0, 0, "R6");
    // R3 plain code, then R6 pulse with start held in open
    step(0, 1, 0, 0, 0, 0, "R3");
    code("R3");
    step(0, 1, 0, 0, 0, 0, "R6");
    code("R6");
    idle(1, "R6");
    // R4: pauses
    step(0, 1, 0, 0, 0, 0, "R4");
    idle(4, "R4");
    step(0, 0, 1, 1, 0, 0, "R4");
    idle(7, "R4");
    step(0, 0, 1, 0, 0, 1, "R4");
    idle(3, "R4");
    step(0, 0, 1, 0, 1, 0, "R4");
    idle(5, "R4");
    step(0, 0, 1, 1, 0, 0, "R4");
    idle(2, "R4");
    // R5: wrong colour after first red
    step(0, 1, 0, 0, 0, 0, "R5");
    step(0, 0, 1, 1, 0, 0, "R5");
    step(0, 0, 1, 0, 1, 0, "R5");
    step(0, 0, 1, 0, 0, 1, "R5");
    step(0, 0, 1, 0, 1, 0, "R5");
    step(0, 0, 1, 1, 0, 0, "R5");
    // R5: wrong at the last step, then press with no colour
    step(0, 1, 0, 0, 0, 0, "R5");
    step(0, 0, 1, 1, 0, 0, "R5");
    step(0, 0, 1, 0, 0, 1, "R5");
    step(0, 0, 1, 0, 1, 0, "R5");
    step(0, 0, 1, 0, 0, 1, "R5");
    step(0, 1, 0, 0, 0, 0, "R5");
    step(0, 0, 1, 0, 0, 0, "R5");
    code("R5");
    // R7: multi-flag presses
    step(0, 1, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 1, 1, 0, "R7");
    step(0, 0, 1, 1, 0, 1, "R7");
    step(0, 0, 1, 0, 1, 1, "R7");
    step(0, 0, 1, 1, 1, 1, "R7");
    idle(1, "R7");
    step(0, 1, 0, 0, 0, 0, "R7");
    step(0, 0, 1, 0, 1, 1, "R7");
    code("R7");
    // R1: reset mid-sequence
    step(0, 1, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 1, 0, 0, "R1");
    step(0, 0, 1, 0, 0, 1, "R1");
    step(1, 0, 0, 0, 0, 0, "R1");
    step(0, 0, 1, 0, 1, 0, "R1");
    step(0, 0, 1, 1, 0, 0, "R1");
    idle(2, "R1");
    while (q.size() > 0) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule